// File: doc/BRIEF.md
# Decode Register Port Arbiter

This block sits between a multi-slot instruction decoder and a register file that has fewer read ports than the decoder could ever ask for. Each cycle the decoder presents a group of slots. Each slot has a valid bit and a fixed number of source register specifiers, and each specifier has its own use flag. The arbiter walks the group oldest slot first and hands out read ports with their operand buses. Port numbers rise with slot order, and within a slot operand 0 comes before operand 1.

A slot either gets every port it needs in the same cycle or gets none. The first slot that does not fit is held, and so is every younger slot, so dispatch stays in program order. The grant for each port is registered: the register address, the slot it serves and the operand index. This grant drives the read stage on the following cycle. The dispatch vector and the stall are combinational, so the decoder can retire the dispatched slots and keep the rest in the same cycle.

Top module: `regport_arbiter`

## Requirements
- R1: A valid slot consumes one port for each of its source specifiers whose use flag is set. Use flags are at `src_use[s*2+j]` for slot s and operand j. An invalid slot consumes no port.
- R2: When slot 0 is valid with operand 0 in use, port 0 is granted to slot 0 operand 0. When both of its operands are in use, port 1 is granted to slot 0 operand 1.
- R3: Granted ports are contiguous from port 0. They are ordered by slot index, and within a slot by operand index.
- R4: For each granted port, `port_reg` carries the specifier `src_reg[(s*2+j)*5 +: 5]`, `port_slot[p*2 +: 2]` carries s, and `port_opnd[p]` carries j. These values appear one clock after the group was presented.
- R5: A slot is dispatched exactly when it is valid and the port demand of it and all older slots together is at most 4.
- R6: A slot is never split. A slot that needs more ports than remain gets none and is not dispatched, and every younger slot is held as well, even one that would fit or that needs no port.
- R7: `stall` is high in the same cycle as the group exactly when some valid slot is not dispatched.
- R8: Ports that are not granted have `port_vld` low. Reset clears every `port_vld` bit.
- R9: A specifier whose use flag is clear, or that belongs to an invalid slot, never appears on any port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_valid | input | 4 | Valid bit per decode slot, bit 0 is the oldest |
| src_use | input | 8 | Use flag per source specifier, bit s*2+j |
| src_reg | input | 40 | Source register specifiers, 5 bits each, entry s*2+j |
| slot_dispatch | output | 4 | Slot is fully served this cycle |
| stall | output | 1 | Group is oversubscribed, hold the remaining slots |
| port_vld | output | 4 | Registered grant valid per read port |
| port_reg | output | 20 | Registered register address per port |
| port_slot | output | 8 | Registered slot index per port |
| port_opnd | output | 4 | Registered operand index per port |

## Verification
The bench aims at groups whose demand lands exactly on the port budget and groups one port over it. A design that split a slot there would show a lone operand on port 3, and one that skipped past a blocked slot would dispatch a younger single-operand or zero-operand slot out of order. It also presents invalid slots and clear use flags that carry distinctive register values. A design that counted them would shift every later grant to a higher port and leak a stray address onto a bus. A slot using only its second operand checks that the operand index, not the position, is reported on port 0.

// File: rtl/rpa_pkg.sv
package rpa_pkg;

   // Width of an index over n items, never zero.
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Width of a counter that must hold the value n.
   function automatic int cnt_w(input int n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/rpa_demand.sv
// Per-slot port demand, running totals in program order, fit test.
module rpa_demand #(
   parameter int NUM_SLOTS     = 4,
   parameter int SRCS_PER_SLOT = 2,
   parameter int NUM_PORTS     = 4,
   localparam int CW = rpa_pkg::cnt_w(NUM_SLOTS * SRCS_PER_SLOT)
) (
   input  logic [NUM_SLOTS-1:0]               slot_valid,
   input  logic [NUM_SLOTS*SRCS_PER_SLOT-1:0] src_use,
   output logic [NUM_SLOTS*CW-1:0]            slot_base,
   output logic [NUM_SLOTS-1:0]               slot_fit,
   output logic                               over_sub
);

   logic [(NUM_SLOTS+1)*CW-1:0] upto;

   assign upto[CW-1:0] = '0;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic [CW-1:0] need;
      always_comb begin
         need = '0;
         for (int j = 0; j < SRCS_PER_SLOT; j++) begin
            if (slot_valid[s] && src_use[s*SRCS_PER_SLOT+j]) need = need + CW'(1);
         end
      end
      assign upto[(s+1)*CW +: CW]  = upto[s*CW +: CW] + need;
      assign slot_base[s*CW +: CW] = upto[s*CW +: CW];
      assign slot_fit[s] = slot_valid[s] && (upto[(s+1)*CW +: CW] <= CW'(NUM_PORTS));
   end

   assign over_sub = (upto[NUM_SLOTS*CW +: CW] > CW'(NUM_PORTS));

endmodule

// File: rtl/rpa_grant_map.sv
// Places each operand of each fitting slot on its port.
module rpa_grant_map #(
   parameter int NUM_SLOTS     = 4,
   parameter int SRCS_PER_SLOT = 2,
   parameter int NUM_PORTS     = 4,
   parameter int REG_AW        = 5,
   localparam int CW = rpa_pkg::cnt_w(NUM_SLOTS * SRCS_PER_SLOT),
   localparam int SW = rpa_pkg::idx_w(NUM_SLOTS),
   localparam int OW = rpa_pkg::idx_w(SRCS_PER_SLOT)
) (
   input  logic [NUM_SLOTS-1:0]                      slot_fit,
   input  logic [NUM_SLOTS*SRCS_PER_SLOT-1:0]        src_use,
   input  logic [NUM_SLOTS*SRCS_PER_SLOT*REG_AW-1:0] src_reg,
   input  logic [NUM_SLOTS*CW-1:0]                   slot_base,
   output logic [NUM_PORTS-1:0]                      nxt_vld,
   output logic [NUM_PORTS*REG_AW-1:0]               nxt_reg,
   output logic [NUM_PORTS*SW-1:0]                   nxt_slot,
   output logic [NUM_PORTS*OW-1:0]                   nxt_opnd
);

   always_comb begin
      int pos;
      nxt_vld  = '0;
      nxt_reg  = '0;
      nxt_slot = '0;
      nxt_opnd = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         pos = int'(slot_base[s*CW +: CW]);
         for (int j = 0; j < SRCS_PER_SLOT; j++) begin
            if (slot_fit[s] && src_use[s*SRCS_PER_SLOT+j]) begin
               if (pos < NUM_PORTS) begin
                  nxt_vld[pos]               = 1'b1;
                  nxt_reg[pos*REG_AW +: REG_AW] =
                     src_reg[(s*SRCS_PER_SLOT+j)*REG_AW +: REG_AW];
                  nxt_slot[pos*SW +: SW]     = SW'(s);
                  nxt_opnd[pos*OW +: OW]     = OW'(j);
               end
               pos = pos + 1;
            end
         end
      end
   end

endmodule

// File: rtl/rpa_port_reg.sv
// Output register stage for the port grants.
module rpa_port_reg #(
   parameter int NUM_PORTS = 4,
   parameter int REG_AW    = 5,
   parameter int SW        = 2,
   parameter int OW        = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_PORTS-1:0]        d_vld,
   input  logic [NUM_PORTS*REG_AW-1:0] d_reg,
   input  logic [NUM_PORTS*SW-1:0]     d_slot,
   input  logic [NUM_PORTS*OW-1:0]     d_opnd,
   output logic [NUM_PORTS-1:0]        q_vld,
   output logic [NUM_PORTS*REG_AW-1:0] q_reg,
   output logic [NUM_PORTS*SW-1:0]     q_slot,
   output logic [NUM_PORTS*OW-1:0]     q_opnd
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_vld  <= '0;
         q_reg  <= '0;
         q_slot <= '0;
         q_opnd <= '0;
      end else begin
         q_vld  <= d_vld;
         q_reg  <= d_reg;
         q_slot <= d_slot;
         q_opnd <= d_opnd;
      end
   end

endmodule

// File: rtl/regport_arbiter.sv
// In-order arbiter of decode source reads onto a reduced read-port pool.
module regport_arbiter #(
   parameter int NUM_SLOTS     = 4,
   parameter int SRCS_PER_SLOT = 2,
   parameter int NUM_PORTS     = 4,
   parameter int REG_AW        = 5
) (
   input  logic                                                     clk,
   input  logic                                                     rst_n,
   input  logic [NUM_SLOTS-1:0]                                     slot_valid,
   input  logic [NUM_SLOTS*SRCS_PER_SLOT-1:0]                       src_use,
   input  logic [NUM_SLOTS*SRCS_PER_SLOT*REG_AW-1:0]                src_reg,
   output logic [NUM_SLOTS-1:0]                                     slot_dispatch,
   output logic                                                     stall,
   output logic [NUM_PORTS-1:0]                                     port_vld,
   output logic [NUM_PORTS*REG_AW-1:0]                              port_reg,
   output logic [NUM_PORTS*rpa_pkg::idx_w(NUM_SLOTS)-1:0]           port_slot,
   output logic [NUM_PORTS*rpa_pkg::idx_w(SRCS_PER_SLOT)-1:0]       port_opnd
);

   localparam int CW = rpa_pkg::cnt_w(NUM_SLOTS * SRCS_PER_SLOT);
   localparam int SW = rpa_pkg::idx_w(NUM_SLOTS);
   localparam int OW = rpa_pkg::idx_w(SRCS_PER_SLOT);

   // Elaboration checks: a single slot must always fit, and the pool
   // must be smaller than or equal to the full demand.
   if (NUM_PORTS < SRCS_PER_SLOT) begin : g_bad_ports
      $error("NUM_PORTS must cover one slot's full demand");
   end
   if (NUM_PORTS > NUM_SLOTS * SRCS_PER_SLOT) begin : g_bad_pool
      $error("NUM_PORTS exceeds the largest possible demand");
   end
   if (NUM_SLOTS < 1 || SRCS_PER_SLOT < 1 || REG_AW < 1) begin : g_bad_dim
      $error("dimensions must be positive");
   end

   logic [NUM_SLOTS*CW-1:0]     slot_base;
   logic [NUM_SLOTS-1:0]        slot_fit;
   logic                        over_sub;
   logic [NUM_PORTS-1:0]        nxt_vld;
   logic [NUM_PORTS*REG_AW-1:0] nxt_reg;
   logic [NUM_PORTS*SW-1:0]     nxt_slot;
   logic [NUM_PORTS*OW-1:0]     nxt_opnd;

   rpa_demand #(
      .NUM_SLOTS(NUM_SLOTS), .SRCS_PER_SLOT(SRCS_PER_SLOT), .NUM_PORTS(NUM_PORTS)
   ) u_demand (
      .slot_valid(slot_valid),
      .src_use   (src_use),
      .slot_base (slot_base),
      .slot_fit  (slot_fit),
      .over_sub  (over_sub)
   );

   rpa_grant_map #(
      .NUM_SLOTS(NUM_SLOTS), .SRCS_PER_SLOT(SRCS_PER_SLOT),
      .NUM_PORTS(NUM_PORTS), .REG_AW(REG_AW)
   ) u_map (
      .slot_fit (slot_fit),
      .src_use  (src_use),
      .src_reg  (src_reg),
      .slot_base(slot_base),
      .nxt_vld  (nxt_vld),
      .nxt_reg  (nxt_reg),
      .nxt_slot (nxt_slot),
      .nxt_opnd (nxt_opnd)
   );

   rpa_port_reg #(
      .NUM_PORTS(NUM_PORTS), .REG_AW(REG_AW), .SW(SW), .OW(OW)
   ) u_preg (
      .clk   (clk),
      .rst_n (rst_n),
      .d_vld (nxt_vld),
      .d_reg (nxt_reg),
      .d_slot(nxt_slot),
      .d_opnd(nxt_opnd),
      .q_vld (port_vld),
      .q_reg (port_reg),
      .q_slot(port_slot),
      .q_opnd(port_opnd)
   );

   assign slot_dispatch = slot_fit;
   assign stall         = over_sub;

endmodule

// File: rtl/rpa_checker.sv
module rpa_checker #(
   parameter int NUM_SLOTS     = 4,
   parameter int SRCS_PER_SLOT = 2,
   parameter int NUM_PORTS     = 4,
   parameter int REG_AW        = 5
) (
   input logic                                               clk,
   input logic                                               rst_n,
   input logic [NUM_SLOTS-1:0]                               slot_valid,
   input logic [NUM_SLOTS*SRCS_PER_SLOT-1:0]                 src_use,
   input logic [NUM_SLOTS*SRCS_PER_SLOT*REG_AW-1:0]          src_reg,
   input logic [NUM_SLOTS-1:0]                               slot_dispatch,
   input logic                                               stall,
   input logic [NUM_PORTS-1:0]                               port_vld,
   input logic [NUM_PORTS*REG_AW-1:0]                        port_reg,
   input logic [NUM_PORTS*rpa_pkg::idx_w(NUM_SLOTS)-1:0]     port_slot,
   input logic [NUM_PORTS*rpa_pkg::idx_w(SRCS_PER_SLOT)-1:0] port_opnd
);

   localparam int NQ = NUM_SLOTS * SRCS_PER_SLOT;
   localparam int CW = rpa_pkg::cnt_w(NQ);
   localparam int SW = rpa_pkg::idx_w(NUM_SLOTS);
   localparam int OW = rpa_pkg::idx_w(SRCS_PER_SLOT);

   logic [CW-1:0]          cur_need;
   logic [CW-1:0]          q_need;
   logic [NQ*REG_AW-1:0]   q_src;
   logic [REG_AW-1:0]      q_exp [NUM_PORTS];
   logic [NUM_PORTS-1:0]   vld_inc;

   always_comb begin
      cur_need = '0;
      for (int s = 0; s < NUM_SLOTS; s++)
         for (int j = 0; j < SRCS_PER_SLOT; j++)
            if (slot_dispatch[s] && src_use[s*SRCS_PER_SLOT+j]) cur_need = cur_need + CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_need <= '0;
      else        q_need <= cur_need;
   end

   always_ff @(posedge clk) q_src <= src_reg;

   always_comb begin
      int idx;
      for (int p = 0; p < NUM_PORTS; p++) begin
         idx = int'(port_slot[p*SW +: SW]) * SRCS_PER_SLOT + int'(port_opnd[p*OW +: OW]);
         q_exp[p] = (idx < NQ) ? q_src[idx*REG_AW +: REG_AW] : '0;
      end
   end

   assign vld_inc = port_vld + NUM_PORTS'(1);

   p_dispatch_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_dispatch & ~slot_valid) == '0);

   p_stall_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stall == (|(slot_valid & ~slot_dispatch)));

   p_contiguous_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (port_vld & vld_inc) == '0);

   p_demand_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(port_vld) == int'(q_need));

   p_slot0_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_valid[0] && src_use[0]) |=>
         (port_vld[0] && port_slot[SW-1:0] == '0 && port_opnd[OW-1:0] == '0));

   p_reset_clear_r8: assert property (@(posedge clk)
      !rst_n |=> port_vld == '0);

   for (genvar s = 1; s < NUM_SLOTS; s++) begin : g_order
      p_in_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
         slot_dispatch[s] |-> ((slot_valid[s-1:0] & ~slot_dispatch[s-1:0]) == '0));
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      p_addr_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
         port_vld[p] |-> port_reg[p*REG_AW +: REG_AW] == q_exp[p]);
   end

endmodule

bind regport_arbiter rpa_checker #(
   .NUM_SLOTS(NUM_SLOTS), .SRCS_PER_SLOT(SRCS_PER_SLOT),
   .NUM_PORTS(NUM_PORTS), .REG_AW(REG_AW)
) u_chk (.*);

// File: tb/regport_arbiter_tb.sv
module regport_arbiter_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  slot_valid = '0;
   logic [7:0]  src_use = '0;
   logic [39:0] src_reg = '0;
   logic [3:0]  slot_dispatch;
   logic        stall;
   logic [3:0]  port_vld;
   logic [19:0] port_reg;
   logic [7:0]  port_slot;
   logic [3:0]  port_opnd;

   int n_chk = 0;
   int n_fail = 0;

   logic [3:0]  e_disp;
   logic        e_stall;
   logic [3:0]  e_vld;
   logic [19:0] e_reg;
   logic [7:0]  e_slot;
   logic [3:0]  e_opnd;

   always #10 clk = ~clk;

   regport_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .src_use(src_use),
      .src_reg(src_reg), .slot_dispatch(slot_dispatch), .stall(stall),
      .port_vld(port_vld), .port_reg(port_reg), .port_slot(port_slot),
      .port_opnd(port_opnd)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [39:0] mkregs(input logic [4:0] base);
      logic [39:0] r;
      for (int k = 0; k < 8; k++) r[k*5 +: 5] = base + 5'(k);
      return r;
   endfunction

   // Expected outcome derived from R1..R9.
   task automatic model(input logic [3:0] v, input logic [7:0] u, input logic [39:0] r);
      int rem;
      int n;
      int p;
      logic blocked;
      rem = 4; blocked = 1'b0;
      e_disp = '0; e_vld = '0; e_reg = '0; e_slot = '0; e_opnd = '0;
      for (int s = 0; s < 4; s++) begin
         n = int'(u[s*2]) + int'(u[s*2+1]);
         if (v[s]) begin
            if (!blocked && n <= rem) begin
               e_disp[s] = 1'b1;
               for (int j = 0; j < 2; j++) begin
                  if (u[s*2+j]) begin
                     p = 4 - rem;
                     e_vld[p] = 1'b1;
                     e_reg[p*5 +: 5] = r[(s*2+j)*5 +: 5];
                     e_slot[p*2 +: 2] = 2'(s);
                     e_opnd[p] = 1'(j);
                     rem = rem - 1;
                  end
               end
            end else blocked = 1'b1;
         end
      end
      e_stall = |(v & ~e_disp);
   endtask

   task automatic apply_group(input string req, input logic [3:0] v,
                              input logic [7:0] u, input logic [39:0] r);
      @(negedge clk);
      slot_valid = v; src_use = u; src_reg = r;
      model(v, u, r);
      #2;
      check(req, "dispatch R5", 64'(slot_dispatch), 64'(e_disp));
      check(req, "stall R7", 64'(stall), 64'(e_stall));
      @(posedge clk); #2;
      check(req, "port_vld R8", 64'(port_vld), 64'(e_vld));
      for (int p = 0; p < 4; p++) begin
         if (e_vld[p]) begin
            check(req, $sformatf("port%0d reg R4", p), 64'(port_reg[p*5 +: 5]), 64'(e_reg[p*5 +: 5]));
            check(req, $sformatf("port%0d slot R3", p), 64'(port_slot[p*2 +: 2]), 64'(e_slot[p*2 +: 2]));
            check(req, $sformatf("port%0d opnd R3", p), 64'(port_opnd[p]), 64'(e_opnd[p]));
         end
      end
   endtask

   task automatic t_reset;
      #2;
      check("R8", "port_vld in reset", 64'(port_vld), 64'h0);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_four_single;
      apply_group("R3", 4'b1111, 8'b0101_0101, mkregs(5'd1));
      check("R3", "port3 slot", 64'(port_slot[7:6]), 64'd3);
   endtask

   task automatic t_slot0_pair;
      apply_group("R2", 4'b0011, 8'b0000_1111, mkregs(5'd9));
      check("R2", "port1 opnd", 64'(port_opnd[1]), 64'd1);
      check("R2", "port1 slot", 64'(port_slot[3:2]), 64'd0);
   endtask

   task automatic t_no_split;
      // 2+1+2+1 ports: slot 2 does not fit, slot 3 held despite fitting
      apply_group("R6", 4'b1111, 8'b0111_0111, mkregs(5'd16));
      check("R6", "slot3 held", 64'(slot_dispatch[3]), 64'd0);
      check("R6", "port3 idle", 64'(port_vld[3]), 64'd0);
   endtask

   task automatic t_exact_fit;
      apply_group("R5", 4'b0110, 8'b0011_1100, mkregs(5'd3));
   endtask

   task automatic t_invalid_slots;
      // slot 0 and 2 invalid with uses set: they must take no port
      apply_group("R1", 4'b1010, 8'b1111_1111, mkregs(5'd20));
      check("R1", "port0 slot", 64'(port_slot[1:0]), 64'd1);
      check("R9", "port0 not slot0", 64'(port_reg[4:0] == 5'd20), 64'd0);
   endtask

   task automatic t_second_only;
      apply_group("R9", 4'b0001, 8'b0000_0010, mkregs(5'd12));
      check("R9", "port0 opnd", 64'(port_opnd[0]), 64'd1);
      check("R9", "port0 reg", 64'(port_reg[4:0]), 64'd13);
   endtask

   task automatic t_zero_demand_held;
      apply_group("R6", 4'b1111, 8'b0011_1111, mkregs(5'd0));
      check("R7", "stall raised", 64'(stall), 64'd1);
   endtask

   task automatic t_idle;
      apply_group("R8", 4'b0000, 8'b1111_1111, mkregs(5'd7));
   endtask

   task automatic t_oversub_head;
      apply_group("R7", 4'b1110, 8'b1111_1101, mkregs(5'd24));
   endtask

   initial begin
      #(20 * 20000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (2) @(posedge clk);
      t_reset();
      t_four_single();
      t_slot0_pair();
      t_no_split();
      t_exact_fit();
      t_invalid_slots();
      t_second_only();
      t_zero_demand_held();
      t_oversub_head();
      t_idle();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule